// File: doc/BRIEF.md
# Smart-Card Serial Transceiver with Parity-Error Signalling

This block is a half-duplex asynchronous transceiver for a single-wire smart-card link. Transmit and receive share one line that is pulled up outside the chip. The block therefore never drives the line high. Its output `line_drive_low` asks the pad to pull the line low, and a value of 0 leaves the line to the pull-up.

A frame is built from the following bits:
- a low start bit;
- eight data bits, least significant first;
- an even-parity bit;
- a high stop bit that also serves as the guard time.

Each bit lasts `OVS` pulses of the oversampling tick input `os_tick`.

When a received frame fails its parity check and `perr_sig_en` is set, the receiver answers the sender by holding the line low from the guard time onward. It keeps doing so until software reads the receive buffer. On the transmit side, `tx_done` is timed to fall in the middle of the stop slot. At that moment `line_level` shows whether the card is pulling the line low to report an error.

Both data paths are valid/ready streams:
- **Transmit.** A byte is taken on the cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` falls while a frame is in flight, while a frame is being received, while the line is low and while the error signal is being driven. The source must hold `tx_data` until it is accepted.
- **Receive.** The one-entry buffer shows `rx_valid` until a cycle with `rx_ready` high, which counts as a read. The buffer holds a single frame. A frame that completes before the previous one has been read replaces it.

Top module: `sc_uart`

## Requirements
- R1: A transmitted frame sends the following bits, each lasting `OVS` ticks:
  - a start bit with the line pulled low;
  - tx_data bit 0 through bit 7, where a 0 pulls the line low and a 1 releases it;
  - an even-parity bit equal to the XOR of the eight data bits;
  - a stop bit with the line released.
- R2: `line_drive_low` is 1 only to pull the line low. It is 0 after reset and whenever the block is neither sending a 0 bit nor signalling an error.
- R3: `tx_ready` is 1 only when all of the following hold:
  - no frame is being sent or received;
  - the synchronised line is high;
  - no error signal is being driven.

  A byte is accepted on a cycle with `tx_valid` and `tx_ready` both high.
- R4: `tx_done` is a one-cycle pulse in the cycle after the `OVS/2`-th tick of the stop slot. In that cycle `line_level`, which is the line delayed by two clock cycles, shows whether the card is holding the line low.
- R5: A low level starts a receive only if the line is still low `OVS/2` ticks later. A shorter low pulse produces no received byte.
- R6: Received data bits are assembled least significant first. `rx_valid` rises `OVS/2` ticks after the parity sample, and both `rx_data` and `rx_valid` hold until a read (`rx_valid` and `rx_ready` high in the same cycle) clears `rx_valid`.
- R7: `perr_flag` is set together with `rx_valid` when the nine received data and parity bits have an odd number of ones. A read clears it.
- R8: With `perr_sig_en` = 1, a parity failure makes the block pull the line low from the moment `rx_valid` rises. With `perr_sig_en` = 0 the line is never pulled for an error. A read releases the pull in the same cycle that it clears `perr_flag`.
- R9: While the error signal is driven, `rx_valid` and `perr_flag` stay 1 and `tx_ready` stays 0.
- R10: Bits seen on the line while the block transmits are ignored. No received byte results from the block's own frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle oversampling tick, `OVS` per bit |
| perr_sig_en | input | 1 | Enables driving the error signal on a receive parity failure |
| line_in | input | 1 | Level of the shared line |
| line_drive_low | output | 1 | 1 pulls the shared line low, 0 releases it |
| line_level | output | 1 | Synchronised line level, readable as status |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_done | output | 1 | Pulse in the middle of the stop slot of a sent frame |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| rx_ready | input | 1 | Read of the receive buffer when `rx_valid` is high |
| perr_flag | output | 1 | Parity failure of the byte in the buffer |

## Verification
The assertions check the following on every cycle:
- an active error signal always coincides with a full buffer and a set parity flag;
- a read during the error signal releases the line and clears the flag at the next edge;
- the error signal starts only while enabled;
- no received byte appears right after the block's own transmission;
- `tx_done` is a single-cycle pulse inside a transmission;
- an accepted byte makes the transmitter busy.

The exact bit order and timing on the line depend on data and tick counting, and only the bench's scenarios can show them:
- the parity bit value;
- the position of `tx_done`;
- mid-bit start qualification against a short glitch;
- correct reassembly of every byte value.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_GUARD,
    RX_HOLD
  } rx_state_t;

  // start bit, parity bit and stop bit added to the data bits
  localparam int unsigned FRAME_OVERHEAD = 3;
endpackage

// File: rtl/sc_uart_sync.sv
module sc_uart_sync #(
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RESET_VAL;
      q    <= RESET_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx #(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          drive_low,
  output logic          done
);
  import sc_uart_pkg::*;

  localparam int unsigned NB   = DW + FRAME_OVERHEAD;
  localparam int unsigned IW   = $clog2(NB);
  localparam int unsigned TW   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned HALF = OVS / 2;

  logic [NB-1:0] frame;
  logic [IW-1:0] idx;
  logic [TW-1:0] tcnt;
  logic          last_bit;

  assign last_bit  = (idx == IW'(NB - 1));
  assign drive_low = busy && !frame[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '1;
      idx   <= '0;
      tcnt  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= tick && busy && last_bit && (tcnt == TW'(HALF - 1));
      if (start && !busy) begin
        frame <= {1'b1, ^data, data, 1'b0};
        idx   <= '0;
        tcnt  <= '0;
        busy  <= 1'b1;
      end else if (busy && tick) begin
        if (tcnt == TW'(OVS - 1)) begin
          tcnt <= '0;
          if (last_bit) busy <= 1'b0;
          else          idx  <= idx + 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx #(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic          block,
  input  logic          err_en,
  input  logic          rd,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          err_drive,
  output logic          busy
);
  import sc_uart_pkg::*;

  localparam int unsigned TW   = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned BW   = $clog2(DW + 1);
  localparam int unsigned HALF = OVS / 2;

  rx_state_t     st;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bitn;
  logic [DW:0]   shreg;
  logic          bad;

  assign bad  = ^shreg;
  assign busy = (st != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      tcnt      <= '0;
      bitn      <= '0;
      shreg     <= '0;
      valid     <= 1'b0;
      data      <= '0;
      perr      <= 1'b0;
      err_drive <= 1'b0;
    end else begin
      if (rd) begin
        valid     <= 1'b0;
        perr      <= 1'b0;
        err_drive <= 1'b0;
      end
      unique case (st)
        RX_IDLE: begin
          tcnt <= '0;
          if (!block && !line) st <= RX_START;
        end
        RX_START: if (tick) begin
          if (tcnt == TW'(HALF - 1)) begin
            tcnt <= '0;
            bitn <= '0;
            st   <= line ? RX_IDLE : RX_DATA;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (tcnt == TW'(OVS - 1)) begin
            tcnt  <= '0;
            shreg <= {line, shreg[DW:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == BW'(DW)) st <= RX_GUARD;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_GUARD: if (tick) begin
          if (tcnt == TW'(HALF - 1)) begin
            tcnt      <= '0;
            valid     <= 1'b1;
            data      <= shreg[DW-1:0];
            perr      <= bad;
            err_drive <= bad && err_en;
            st        <= RX_HOLD;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_HOLD: begin
          if (line && !err_drive) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          perr_sig_en,
  input  logic          line_in,
  output logic          line_drive_low,
  output logic          line_level,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          tx_done,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic          perr_flag
);
  logic line_s;
  logic tx_busy;
  logic tx_low;
  logic rx_busy;
  logic err_drive;
  logic rd;

  sc_uart_sync #(.RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (line_in),
    .q    (line_s)
  );

  assign tx_ready = !tx_busy && !rx_busy && line_s && !err_drive;
  assign rd       = rx_valid && rx_ready;

  sc_uart_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .start    (tx_valid && tx_ready),
    .data     (tx_data),
    .busy     (tx_busy),
    .drive_low(tx_low),
    .done     (tx_done)
  );

  sc_uart_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (os_tick),
    .line     (line_s),
    .block    (tx_busy),
    .err_en   (perr_sig_en),
    .rd       (rd),
    .valid    (rx_valid),
    .data     (rx_data),
    .perr     (perr_flag),
    .err_drive(err_drive),
    .busy     (rx_busy)
  );

  assign line_drive_low = tx_low || err_drive;
  assign line_level     = line_s;
endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic perr_sig_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_done,
  input logic rx_valid,
  input logic rx_ready,
  input logic perr_flag,
  input logic err_drive,
  input logic tx_busy
);
  // R9: the error signal never outlives the buffered byte and its flag
  assert_err_holds_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_drive |-> (rx_valid && perr_flag));

  // R8: a read releases the line and clears the flag at the next edge
  assert_read_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_drive && rx_valid && rx_ready) |=> (!err_drive && !perr_flag));

  // R8: the error signal only starts while enabled
  assert_err_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_drive) |-> $past(perr_sig_en));

  // R10: the block's own frame never produces a received byte
  assert_no_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> !$past(tx_busy));

  // R4: the done pulse is one cycle long and falls inside a transmission
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  assert_done_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_busy);

  // R3: an accepted byte makes the transmitter busy and drops ready
  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_busy && !tx_ready));
endmodule

bind sc_uart sc_uart_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .perr_sig_en(perr_sig_en),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_done    (tx_done),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .perr_flag  (perr_flag),
  .err_drive  (err_drive),
  .tx_busy    (tx_busy)
);

// File: tb/sim_sc_uart.sv
module sim_sc_uart;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 8;
  localparam int HALF       = OVS / 2;
  localparam int TICKP      = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       perr_sig_en = 1'b0;
  logic       card_low = 1'b0;
  logic       line_in;
  logic       line_drive_low;
  logic       line_level;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       tx_done;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic       perr_flag;

  int n_chk = 0;
  int n_bad = 0;

  assign line_in = !(line_drive_low || card_low);

  sc_uart #(.OVS(OVS), .DW(8)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .os_tick       (os_tick),
    .perr_sig_en   (perr_sig_en),
    .line_in       (line_in),
    .line_drive_low(line_drive_low),
    .line_level    (line_level),
    .tx_data       (tx_data),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_done       (tx_done),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .perr_flag     (perr_flag)
  );

  initial forever #(CLK_PERIOD / 2) clk = !clk;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      os_tick = ((k % TICKP) == 0);
      k++;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n;) begin
      @(posedge clk);
      if (os_tick) i++;
    end
    #1;
  endtask

  task automatic send_tx(input logic [7:0] d, input bit nack);
    logic [10:0] fr;
    fr = {1'b1, ^d, d, 1'b0};
    while (!tx_ready) begin
      @(posedge clk);
      #1;
    end
    tx_data  = d;
    tx_valid = 1'b1;
    @(posedge clk);
    #1;
    tx_valid = 1'b0;
    chk(tx_ready, 0, "R3 ready low while sending");
    for (int b = 0; b < 11; b++) begin
      if (b == 10) card_low = nack;
      wait_ticks(HALF);
      chk(line_drive_low, !fr[b], "R1 tx bit level");
      if (b == 10) begin
        chk(tx_done, 1, "R4 done mid stop");
        chk(line_level, !nack, "R4 line level at done");
      end
      wait_ticks(HALF);
      if (b == 10) card_low = 1'b0;
    end
    wait_ticks(2);
    chk(rx_valid, 0, "R10 own frame not received");
    chk(line_drive_low, 0, "R2 released after frame");
  endtask

  task automatic send_rx(input logic [7:0] d, input bit badpar, input bit en);
    logic [9:0] fr;
    perr_sig_en = en;
    fr = {(^d) ^ badpar, d, 1'b0};
    for (int b = 0; b < 10; b++) begin
      card_low = !fr[b];
      wait_ticks(OVS);
    end
    card_low = 1'b0;
    wait_ticks(HALF);
    chk(rx_valid, 1, "R6 valid after frame");
    chk(rx_data, d, "R6 data lsb first");
    chk(perr_flag, badpar, "R7 parity flag");
    chk(line_drive_low, badpar && en, "R8 error signal");
    if (badpar && en) begin
      repeat (40) @(posedge clk);
      #1;
      chk(line_drive_low, 1, "R8 error held");
      chk(rx_valid, 1, "R9 valid held");
      chk(perr_flag, 1, "R9 flag held");
      chk(tx_ready, 0, "R9 no transmit during error");
    end
    rx_ready = 1'b1;
    @(posedge clk);
    #1;
    rx_ready = 1'b0;
    chk(rx_valid, 0, "R6 read clears valid");
    chk(perr_flag, 0, "R7 read clears flag");
    chk(line_drive_low, 0, "R8 read releases line");
    wait_ticks(HALF);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(line_drive_low, 0, "R2 reset released");
    chk(rx_valid, 0, "R6 reset valid");
    chk(perr_flag, 0, "R7 reset flag");
    chk(tx_ready, 1, "R3 reset ready");
    chk(tx_done, 0, "R4 reset done");

    // short low glitch rejected
    card_low = 1'b1;
    wait_ticks(2);
    card_low = 1'b0;
    wait_ticks(OVS * 12);
    chk(rx_valid, 0, "R5 glitch rejected");
    chk(tx_ready, 1, "R5 idle after glitch");

    for (int d = 0; d < 256; d++) send_tx(8'(d), (d % 7) == 3);
    for (int d = 0; d < 256; d++) send_rx(8'(d), 1'b0, 1'b1);
    for (int d = 0; d < 256; d += 17) begin
      send_rx(8'(d), 1'b1, 1'b1);
      send_rx(8'(d), 1'b1, 1'b0);
    end
    send_tx(8'hA5, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule